// File: doc/BRIEF.md
# Staged Subsystem Reset Sequencer

This block takes the board's active-low power-on reset and turns it into an ordered set of resets and clock enables for a processor subsystem. The power-on input is synchronised to the fast reference clock. Reset assertion is asynchronous on every output. Release is synchronous, and it happens in stages.

Once the synchronised power-on signal goes high, a clock enable for the DSP starts at full rate. A clock enable for the MCU starts at half rate. The MCU needs clock edges to enter its synchronous reset, so its reset stays low while the first 128 of its clock ticks go by. After that the MCU runs.

The DSP reset and the peripheral reset stay asserted until the MCU clears a hold bit in a small control register. The MCU writes that register through an address/data/strobe port that is sampled on MCU clock ticks. The same register gates the slow 32.768 kHz clock enable. While a processor is held in reset, the output enables of the pins it shares with this block are forced off, so those pins act as inputs.

Top module: `rst_sequencer`

## Requirements
- R1: While `por_n` is low, `mcu_rst_n`, `dsp_rst_n`, `per_rst_n`, `mcu_clk_en`, `dsp_clk_en` and `slow_clk_en` are all 0. This holds without waiting for a clock edge.
- R2: After `por_n` rises, `dsp_clk_en` is 0 after the first rising `clk_ref` edge and 1 after the second (two-flop synchroniser). From then on it stays 1 while `por_n` stays high.
- R3: With `DIV2`=1, `mcu_clk_en` is high on alternate `clk_ref` cycles, never two cycles in a row. It starts pulsing while `mcu_rst_n` is still 0.
- R4: `mcu_rst_n` goes to 1 at the `clk_ref` edge that ends the 128th `mcu_clk_en` pulse (`MCU_RST_CYCLES`), and not before.
- R5: After the MCU leaves reset, `dsp_rst_n` and `per_rst_n` stay 0 until a write clears the hold bit. The hold bit is bit 0 of the control register at address 0, and 1 means hold.
- R6: Writing 1 to bit 0 of address 0 drives `dsp_rst_n` and `per_rst_n` back to 0 at any time. Writing 0 releases them. The change is visible one `clk_ref` cycle after the sampling tick.
- R7: `slow_clk_en` follows bit 1 of the control register at address 0. That bit is 0 after power-on reset, so the slow clock stays gated until the MCU sets it.
- R8: Writes to any address other than 0 leave both control bits unchanged. Writes take effect only on a `clk_ref` edge where `mcu_clk_en` is 1 and `mcu_rst_n` is 1.
- R9: `dsp_clk_en` is 1 on every cycle while `dsp_rst_n` is held low after synchronised release, so the DSP sees clock edges during reset.
- R10: `mcu_oe_out` is all zeros while `mcu_rst_n` is 0, and equals `mcu_oe_in` otherwise. `dsp_oe_out` is all zeros while `dsp_rst_n` is 0, and equals `dsp_oe_in` otherwise.
- R11: A drop of `por_n` during operation asserts all resets at once. It also returns the control register to hold=1, slow=0, and the full staged sequence repeats on the next release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Full-rate reference clock |
| por_n | input | 1 | External power-on reset, active low, asynchronous |
| wr_en | input | 1 | Control register write strobe |
| wr_addr | input | ADDR_W | Control register write address |
| wr_data | input | 2 | Write data: bit 0 hold, bit 1 slow clock enable |
| mcu_oe_in | input | MCU_IO_W | MCU-side output enables for shared pins |
| dsp_oe_in | input | DSP_IO_W | DSP-side output enables for shared pins |
| mcu_clk_en | output | 1 | Gated half-rate MCU clock enable |
| mcu_rst_n | output | 1 | MCU synchronous reset, active low |
| dsp_clk_en | output | 1 | Gated full-rate DSP clock enable |
| dsp_rst_n | output | 1 | DSP reset, active low |
| per_rst_n | output | 1 | Peripheral asynchronous reset, active low |
| slow_clk_en | output | 1 | Slow clock gate enable |
| mcu_oe_out | output | MCU_IO_W | Overridden MCU pin output enables |
| dsp_oe_out | output | DSP_IO_W | Overridden DSP pin output enables |

## Verification
The bench counts MCU clock pulses during the reset window. A counter that is off by one, or that counts reference cycles instead of MCU ticks, shows up as a wrong pulse count. It also checks that the pulses really alternate, which a design without the divider fails.

The bench walks a table of control writes, including writes to unused addresses. A decoder that ignores the address would corrupt the hold or slow-clock bits on those writes.

The bench also drops power-on reset mid-cycle and samples before the next edge. A design with synchronous assertion, or one whose control register survives power-on reset, releases the DSP or the slow clock too early on the next start-up.

// File: rtl/rst_sequencer.sv
module rst_sequencer #(
  parameter int DIV2           = 1,
  parameter int MCU_RST_CYCLES = 128,
  parameter int ADDR_W         = 4,
  parameter int MCU_IO_W       = 8,
  parameter int DSP_IO_W       = 8
) (
  input  logic                clk_ref,
  input  logic                por_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [1:0]          wr_data,
  input  logic [MCU_IO_W-1:0] mcu_oe_in,
  input  logic [DSP_IO_W-1:0] dsp_oe_in,
  output logic                mcu_clk_en,
  output logic                mcu_rst_n,
  output logic                dsp_clk_en,
  output logic                dsp_rst_n,
  output logic                per_rst_n,
  output logic                slow_clk_en,
  output logic [MCU_IO_W-1:0] mcu_oe_out,
  output logic [DSP_IO_W-1:0] dsp_oe_out
);
  localparam int CNT_W = $clog2(MCU_RST_CYCLES) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MCU_RST_CYCLES - 1);

  logic [1:0]       por_s;
  logic             run;
  logic             phase;
  logic [CNT_W-1:0] tick_cnt;
  logic             hold_q;
  logic             slow_q;

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n) por_s <= 2'b00;
    else        por_s <= {por_s[0], 1'b1};

  assign run = por_s[1];

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n)   phase <= 1'b0;
    else if (run) phase <= ~phase;

  generate
    if (DIV2 != 0) begin : g_half
      assign mcu_clk_en = run & phase;
    end else begin : g_full
      assign mcu_clk_en = run;
    end
  endgenerate

  assign dsp_clk_en = run;

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n) begin
      tick_cnt  <= '0;
      mcu_rst_n <= 1'b0;
    end else if (mcu_clk_en && !mcu_rst_n) begin
      if (tick_cnt == LAST) mcu_rst_n <= 1'b1;
      else                  tick_cnt  <= tick_cnt + 1'b1;
    end

  always_ff @(posedge clk_ref or negedge por_n)
    if (!por_n) begin
      hold_q <= 1'b1;
      slow_q <= 1'b0;
    end else if (wr_en && mcu_clk_en && mcu_rst_n && wr_addr == '0) begin
      hold_q <= wr_data[0];
      slow_q <= wr_data[1];
    end

  assign dsp_rst_n   = run & mcu_rst_n & ~hold_q;
  assign per_rst_n   = dsp_rst_n;
  assign slow_clk_en = run & mcu_rst_n & slow_q;
  assign mcu_oe_out  = mcu_rst_n ? mcu_oe_in : '0;
  assign dsp_oe_out  = dsp_rst_n ? dsp_oe_in : '0;

  always_ff @(posedge clk_ref)
    if (por_n === 1'b0)
      assert_por_holds_all_R1: assert (!mcu_rst_n && !dsp_rst_n && !per_rst_n && !slow_clk_en);

  generate
    if (DIV2 != 0) begin : g_chk_half
      assert_mcu_tick_alternates_R3: assert property (@(posedge clk_ref) disable iff (!por_n)
        mcu_clk_en |=> !mcu_clk_en);
    end
  endgenerate

  assert_mcu_rel_on_tick_R4: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(mcu_rst_n) |-> $past(mcu_clk_en));

  assert_dsp_after_mcu_R5: assert property (@(posedge clk_ref) disable iff (!por_n)
    $rose(dsp_rst_n) |-> (mcu_rst_n && $past(mcu_rst_n)));

  assert_slow_gated_in_rst_R7: assert property (@(posedge clk_ref) disable iff (!por_n)
    !mcu_rst_n |-> !slow_clk_en);

  assert_dsp_clk_in_rst_R9: assert property (@(posedge clk_ref) disable iff (!por_n)
    mcu_clk_en |-> dsp_clk_en);

  assert_per_tracks_dsp_R6: assert property (@(posedge clk_ref) disable iff (!por_n)
    $fell(dsp_rst_n) |-> !per_rst_n);
endmodule

// File: tb/tb_rst_sequencer.sv
module tb_rst_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {addr[3:0], data[1:0], exp_dsp_rst_n, exp_slow}
  localparam logic [7:0] VEC [NV] = '{
    {4'd0, 2'b00, 1'b1, 1'b0},
    {4'd0, 2'b10, 1'b1, 1'b1},
    {4'd1, 2'b01, 1'b1, 1'b1},
    {4'd0, 2'b11, 1'b0, 1'b1},
    {4'd3, 2'b00, 1'b0, 1'b1},
    {4'd0, 2'b00, 1'b1, 1'b0}
  };

  logic clk_ref = 1'b0;
  logic por_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [1:0] wr_data = '0;
  logic [7:0] mcu_oe_in = 8'hFF;
  logic [7:0] dsp_oe_in = 8'hA5;
  logic mcu_clk_en, mcu_rst_n, dsp_clk_en, dsp_rst_n, per_rst_n, slow_clk_en;
  logic [7:0] mcu_oe_out, dsp_oe_out;
  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  rst_sequencer dut (
    .clk_ref(clk_ref), .por_n(por_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .mcu_oe_in(mcu_oe_in), .dsp_oe_in(dsp_oe_in),
    .mcu_clk_en(mcu_clk_en), .mcu_rst_n(mcu_rst_n), .dsp_clk_en(dsp_clk_en),
    .dsp_rst_n(dsp_rst_n), .per_rst_n(per_rst_n), .slow_clk_en(slow_clk_en),
    .mcu_oe_out(mcu_oe_out), .dsp_oe_out(dsp_oe_out)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_ctrl(input logic [3:0] a, input logic [1:0] d);
    @(negedge clk_ref);
    while (!mcu_clk_en) @(negedge clk_ref);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk_ref);
    wr_en = 1'b0;
  endtask

  task automatic start_up(input string tag);
    int pulses = 0;
    bit prev = 0;
    bit twice = 0;
    bit dsp_gap = 0;
    @(negedge clk_ref);
    por_n = 1'b1;
    @(negedge clk_ref);
    check({tag, " R2 clk_en after 1 edge"}, dsp_clk_en, 0);
    @(negedge clk_ref);
    check({tag, " R2 clk_en after 2 edges"}, dsp_clk_en, 1);
    for (int i = 0; i < 1000 && !mcu_rst_n; i++) begin
      if (mcu_clk_en) pulses++;
      if (mcu_clk_en && prev) twice = 1;
      if (!dsp_clk_en) dsp_gap = 1;
      prev = mcu_clk_en;
      @(negedge clk_ref);
    end
    check({tag, " R4 MCU ticks in reset"}, pulses, 128);
    check({tag, " R3 ticks alternate"}, twice, 0);
    check({tag, " R9 dsp clock during reset"}, dsp_gap, 0);
    check({tag, " R5 dsp held after mcu release"}, dsp_rst_n, 0);
    check({tag, " R5 per held after mcu release"}, per_rst_n, 0);
    check({tag, " R7 slow gated after start"}, slow_clk_en, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_ref);
    check("R1 resets low in por", {mcu_rst_n, dsp_rst_n, per_rst_n}, 0);
    check("R1 enables low in por", {mcu_clk_en, dsp_clk_en, slow_clk_en}, 0);
    check("R10 oe forced in por", {mcu_oe_out, dsp_oe_out}, 0);

    start_up("first");
    check("R10 mcu oe passes", mcu_oe_out, 8'hFF);
    check("R10 dsp oe forced", dsp_oe_out, 8'h00);

    for (int i = 0; i < NV; i++) begin
      write_ctrl(VEC[i][7:4], VEC[i][3:2]);
      check($sformatf("R6 R8 vec%0d dsp_rst_n", i), dsp_rst_n, VEC[i][1]);
      check($sformatf("R6 vec%0d per_rst_n", i), per_rst_n, VEC[i][1]);
      check($sformatf("R7 R8 vec%0d slow", i), slow_clk_en, VEC[i][0]);
    end
    check("R10 dsp oe passes", dsp_oe_out, 8'hA5);

    write_ctrl(4'd0, 2'b10);
    check("R7 slow on before drop", slow_clk_en, 1);
    @(negedge clk_ref);
    #2 por_n = 1'b0;
    #1;
    check("R11 async reset assert", {mcu_rst_n, dsp_rst_n, per_rst_n, slow_clk_en}, 0);
    check("R11 R10 oe forced", {mcu_oe_out, dsp_oe_out}, 0);
    repeat (2) @(negedge clk_ref);
    start_up("restart R11");
    write_ctrl(4'd0, 2'b00);
    check("R11 release after restart", {dsp_rst_n, per_rst_n, slow_clk_en}, 3'b110);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule